// File: doc/BRIEF.md
# Watchdog Timer with Seconds or Minutes Timebase

This block is a watchdog timer programmed through a small bank of byte-wide registers: a control/status register, a configuration register and a count value split into a low and a high byte. Software loads a count, and the block decrements it on every unit tick until it reaches zero. A unit tick is either the incoming one-second tick or every sixtieth of those ticks, chosen by a configuration bit. When the count runs out, the block raises a reset pulse of fixed length and latches a sticky status bit.

The configuration register also decides where the timeout goes. A keyboard-reset output and a power-good pulse output follow the reset pulse only when their enable bits are set. A four-bit field picks one of sixteen interrupt lines, which is driven when the timeout-output enable is set. Any write to a count byte reloads the down-counter and restarts the minute prescaler, so that write is the keepalive. A count of zero holds the timer stopped. The register port is plain: a write strobe with an address and data, and a read data bus that follows the address in the same cycle. No flow control is involved.

Top module: `wdog_timebase`

## Requirements
- R1: After reset, every register reads 0 and all outputs (wdt_rst, kbd_rst, pwrok_pulse, irq_line) are low.
- R2: Configuration at address 0x72, count low byte at 0x73 and count high byte at 0x74 read back the last value written. Any address outside 0x71 to 0x74 reads 0.
- R3: With configuration bit 7 set (seconds), a count N loaded by a write expires on the Nth sec_tick after that write. wdt_rst is high from the clock edge that samples that tick.
- R4: With configuration bit 7 clear (minutes), a count N expires on the (60*N)th sec_tick after the reload.
- R5: A write to 0x73 or 0x74 reloads the down-counter with the full 16-bit count, {high byte, low byte}, and clears the minute prescaler. If a sec_tick arrives in the same cycle as that write, the reload wins and the tick is not counted.
- R6: A count of zero, whether loaded before the timer starts or written while it runs, stops the timer, and no sec_tick then causes an expiry.
- R7: An expiry holds wdt_rst high for exactly RST_CLKS clocks. The counter then stays at zero and does not expire again until the next reload.
- R8: Bit 0 of 0x71 is a sticky status bit that is set on expiry. Writing 1 to it clears it, and writing 0 has no effect. If an expiry and a clearing write fall in the same cycle, the bit ends up set.
- R9: kbd_rst equals wdt_rst when configuration bit 6 is set and is 0 otherwise. pwrok_pulse equals wdt_rst when configuration bit 4 is set and is 0 otherwise.
- R10: While wdt_rst is high, with configuration bit 5 set and configuration bits 3:0 = k, where k is not 0, only irq_line[k] is high. Select value 0, or bit 5 clear, drives no line.
- R11: With CNT_W = 8, the high-byte register is absent. Address 0x74 reads 0, and a write to it neither stores data nor reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-clock pulse once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| wdt_rst | output | 1 | Reset pulse on timeout |
| kbd_rst | output | 1 | Keyboard-reset copy of the pulse, gated by its enable |
| pwrok_pulse | output | 1 | Power-good copy of the pulse, gated by its enable |
| irq_line | output | 16 | One-hot selected interrupt line during the pulse |

## Verification
Two functions can fall in the same cycle here. A keepalive write can coincide with the sec_tick that would have taken the count from one to zero, and a write of 1 to the status bit can coincide with the expiry that sets it. The bench drives the write strobe and the tick in the same clock. It then judges the first case by the absence of a reset pulse, followed by a full fresh countdown. It judges the second case by reading the status bit back as set after the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h71;
  localparam logic [7:0] ADDR_CFG    = 8'h72;
  localparam logic [7:0] ADDR_CNT_LO = 8'h73;
  localparam logic [7:0] ADDR_CNT_HI = 8'h74;

  localparam int IRQ_N  = 16;
  localparam int MIN_DIV = 60;

  typedef struct packed {
    logic       unit_sec;   // bit 7: 1 = seconds, 0 = minutes
    logic       kbd_en;     // bit 6
    logic       out_en;     // bit 5
    logic       pwrok_en;   // bit 4
    logic [3:0] irq_sel;    // bits 3:0
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             expire_evt,
  output logic [7:0]       reg_rdata,
  output wdog_cfg_t        cfg,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             status
);
  localparam bit HAS_HI = (CNT_W > 8);

  logic [7:0] cfg_q;
  logic [7:0] lo_q;
  logic [7:0] hi_q;
  logic       wr_lo;
  logic       wr_hi;
  logic       st_clr;

  assign wr_lo  = reg_wr && (reg_addr == ADDR_CNT_LO);
  assign st_clr = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];
  assign cfg    = wdog_cfg_t'(cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lo_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CFG)    cfg_q <= reg_wdata;
      if (reg_addr == ADDR_CNT_LO) lo_q  <= reg_wdata;
    end
  end

  generate
    if (HAS_HI) begin : g_hi
      assign wr_hi = reg_wr && (reg_addr == ADDR_CNT_HI);
      always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= reg_wdata;
      end
      assign load_val = wr_hi ? {reg_wdata, lo_q} : {hi_q, reg_wdata};
    end else begin : g_no_hi
      assign wr_hi    = 1'b0;
      assign hi_q     = '0;
      assign load_val = reg_wdata;
    end
  endgenerate

  assign load = wr_lo || wr_hi;

  // Sticky status: a new expiry outranks a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rst_n)          status <= 1'b0;
    else if (expire_evt) status <= 1'b1;
    else if (st_clr)     status <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL:   reg_rdata = {7'b0, status};
      ADDR_CFG:    reg_rdata = cfg_q;
      ADDR_CNT_LO: reg_rdata = lo_q;
      ADDR_CNT_HI: reg_rdata = hi_q;
      default:     reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sec_tick,
  input  logic unit_sec,
  output logic unit_tick
);
  localparam int PC_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PC_W-1:0] LAST = PC_W'(DIV - 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || unit_sec) begin
      pc_q <= '0;
    end else if (sec_tick) begin
      pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
    end
  end

  assign unit_tick = sec_tick && (unit_sec || (pc_q == LAST));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             unit_tick,
  output logic             expire_evt
);
  logic [CNT_W-1:0] cnt_q;

  // A reload outranks a unit tick in the same cycle.
  assign expire_evt = !load && unit_tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load)                       cnt_q <= load_val;
    else if (unit_tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int RST_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  wdog_cfg_t        cfg,
  output logic             wdt_rst,
  output logic             kbd_rst,
  output logic             pwrok_pulse,
  output logic [IRQ_N-1:0] irq_line
);
  localparam int PW = $clog2(RST_CLKS + 1);

  logic [PW-1:0] left_q;
  logic          active;

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (fire)          left_q <= PW'(RST_CLKS);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign active      = (left_q != '0);
  assign wdt_rst     = active;
  assign kbd_rst     = active && cfg.kbd_en;
  assign pwrok_pulse = active && cfg.pwrok_en;

  genvar i;
  generate
    for (i = 0; i < IRQ_N; i++) begin : g_irq
      if (i == 0) begin : g_none
        assign irq_line[i] = 1'b0;
      end else begin : g_line
        assign irq_line[i] = active && cfg.out_en && (cfg.irq_sel == 4'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RST_CLKS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        wdt_rst,
  output logic        kbd_rst,
  output logic        pwrok_pulse,
  output logic [15:0] irq_line
);
  wdog_cfg_t        cfg;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             status_q;
  logic             unit_tick;
  logic             expire_evt;

  wdog_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .expire_evt(expire_evt), .reg_rdata(reg_rdata),
    .cfg(cfg), .load(load), .load_val(load_val), .status(status_q)
  );

  wdog_prescale #(.DIV(MIN_DIV)) pre_i (
    .clk(clk), .rst_n(rst_n), .clr(load), .sec_tick(sec_tick),
    .unit_sec(cfg.unit_sec), .unit_tick(unit_tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .unit_tick(unit_tick), .expire_evt(expire_evt)
  );

  wdog_pulse #(.RST_CLKS(RST_CLKS)) pls_i (
    .clk(clk), .rst_n(rst_n), .fire(expire_evt), .cfg(cfg),
    .wdt_rst(wdt_rst), .kbd_rst(kbd_rst), .pwrok_pulse(pwrok_pulse),
    .irq_line(irq_line)
  );
endmodule

// File: rtl/wdog_timebase_chk.sv
module wdog_timebase_chk #(
  parameter int CNT_W    = 16,
  parameter int RST_CLKS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic        wdt_rst,
  input logic        kbd_rst,
  input logic        pwrok_pulse,
  input logic [15:0] irq_line,
  input logic        status
);
  logic [15:0] run_q;
  logic        cnt_wr;

  assign cnt_wr = reg_wr && ((reg_addr == 8'h73) || ((CNT_W > 8) && (reg_addr == 8'h74)));

  always_ff @(posedge clk) begin
    if (!rst_n)       run_q <= '0;
    else if (wdt_rst) run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 1'b1;
    else              run_q <= '0;
  end

  // R9
  kbd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) kbd_rst |-> wdt_rst);
  // R9
  pwrok_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) pwrok_pulse |-> wdt_rst);
  // R10
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_line));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq_line != 16'h0) |-> wdt_rst);
  // R8
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wdt_rst) |-> status);
  // R3
  tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wdt_rst) |-> $past(sec_tick));
  // R5
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wdt_rst) |-> !$past(cnt_wr));
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(wdt_rst) |-> run_q >= 16'(RST_CLKS));
endmodule

bind wdog_timebase wdog_timebase_chk #(.CNT_W(CNT_W), .RST_CLKS(RST_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wdt_rst(wdt_rst), .kbd_rst(kbd_rst),
  .pwrok_pulse(pwrok_pulse), .irq_line(irq_line), .status(status_q)
);

// File: tb/wdog_timebase_tb_top.sv
module wdog_timebase_tb_top;
  localparam int RST = 16;
  localparam int NV  = 6;
  // {cfg, count}
  localparam logic [23:0] VEC [NV] = '{
    {8'h80, 16'd3}, {8'hC0, 16'd1}, {8'hB5, 16'd5},
    {8'h50, 16'd2}, {8'hA0, 16'h0102}, {8'h2F, 16'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, reg_wr = 1'b0, wr8 = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] rdata, rdata8;
  logic wdt_rst, kbd_rst, pwrok, rst8, kbd8, pwrok8;
  logic [15:0] irq, irq8;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_timebase #(.CNT_W(16), .RST_CLKS(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .wdt_rst(wdt_rst), .kbd_rst(kbd_rst), .pwrok_pulse(pwrok), .irq_line(irq));

  wdog_timebase #(.CNT_W(8), .RST_CLKS(RST)) dut8_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(wr8),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata8),
    .wdt_rst(rst8), .kbd_rst(kbd8), .pwrok_pulse(pwrok8), .irq_line(irq8));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] a, logic [7:0] d, logic w, logic t, logic w8);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = w; sec_tick = t; wr8 = w8;
    @(negedge clk);
    reg_wr = 1'b0; sec_tick = 1'b0; wr8 = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cyc(a, d, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = rdata;
  endtask

  task automatic wait_quiet();
    repeat (RST + 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rst", int'(wdt_rst), 0);
    check("R1 outs", int'({kbd_rst, pwrok, irq}), 0);
    for (int a = 8'h71; a <= 8'h74; a++) begin
      rd(8'(a), v); check("R1 reg", int'(v), 0);
    end
    // R2 readback
    wr(8'h72, 8'h3C); rd(8'h72, v); check("R2 cfg", int'(v), 'h3C);
    wr(8'h74, 8'h12); rd(8'h74, v); check("R2 hi", int'(v), 'h12);
    wr(8'h73, 8'h34); rd(8'h73, v); check("R2 lo", int'(v), 'h34);
    rd(8'h70, v); check("R2 unmapped", int'(v), 0);
    wr(8'h74, 8'h00); wr(8'h73, 8'h00);

    // Table walk: R3 R4 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      logic [7:0] c; logic [15:0] n; int nt; int len; logic [15:0] ei;
      c = VEC[k][23:16]; n = VEC[k][15:0];
      nt = c[7] ? int'(n) : int'(n) * 60;
      wr(8'h72, c); wr(8'h74, n[15:8]); wr(8'h73, n[7:0]);
      ticks(nt - 1);
      check(c[7] ? "R3 early" : "R4 early", int'(wdt_rst), 0);
      ticks(1);
      check(c[7] ? "R3 expire" : "R4 expire", int'(wdt_rst), 1);
      check("R9 kbd", int'(kbd_rst), int'(c[6]));
      check("R9 pwrok", int'(pwrok), int'(c[4]));
      ei = (c[5] && c[3:0] != 4'd0) ? (16'd1 << c[3:0]) : 16'd0;
      check("R10 irq", int'(irq), int'(ei));
      rd(8'h71, v); check("R8 status", int'(v), 1);
      len = 1;
      while (wdt_rst) begin @(negedge clk); if (wdt_rst) len++; end
      check("R7 len", len, RST);
      wr(8'h71, 8'h01); rd(8'h71, v); check("R8 clear", int'(v), 0);
    end

    // R7 no repeat expiry after zero
    ticks(5); check("R7 no repeat", int'(wdt_rst), 0);

    // R6 zero count
    wr(8'h72, 8'h80); wr(8'h74, 8'h00); wr(8'h73, 8'h00);
    ticks(10); check("R6 zero idle", int'(wdt_rst), 0);
    rd(8'h71, v); check("R6 status", int'(v), 0);
    wr(8'h73, 8'd3); ticks(2); wr(8'h73, 8'h00);
    ticks(5); check("R6 stop running", int'(wdt_rst), 0);

    // R5 keepalive in minutes: prescaler restarts
    wr(8'h72, 8'h00); wr(8'h73, 8'd1);
    ticks(30); wr(8'h73, 8'd1);
    ticks(59); check("R5 presc clr", int'(wdt_rst), 0);
    ticks(1); check("R5 presc exp", int'(wdt_rst), 1);
    wait_quiet(); wr(8'h71, 8'h01);

    // R5 reload coincides with final tick
    wr(8'h72, 8'h80); wr(8'h73, 8'd2);
    ticks(1);
    cyc(8'h73, 8'd2, 1'b1, 1'b1, 1'b0);
    check("R5 coincide", int'(wdt_rst), 0);
    ticks(1); check("R5 after1", int'(wdt_rst), 0);
    ticks(1); check("R5 after2", int'(wdt_rst), 1);
    wait_quiet();

    // R8 write 0 no effect, then set wins over clear
    wr(8'h71, 8'h00); rd(8'h71, v); check("R8 wr0", int'(v), 1);
    wr(8'h71, 8'h01); wr(8'h73, 8'd1);
    cyc(8'h71, 8'h01, 1'b1, 1'b1, 1'b0);
    rd(8'h71, v); check("R8 set wins", int'(v), 1);
    wait_quiet(); wr(8'h71, 8'h01);

    // R11 8-bit variant
    cyc(8'h74, 8'h55, 1'b0, 1'b0, 1'b1);
    reg_addr = 8'h74; #1; check("R11 hi absent", int'(rdata8), 0);
    cyc(8'h72, 8'h80, 1'b0, 1'b0, 1'b1);
    cyc(8'h73, 8'd3, 1'b0, 1'b0, 1'b1);
    ticks(1);
    cyc(8'h74, 8'h01, 1'b0, 1'b0, 1'b1);
    ticks(1); check("R11 early", int'(rst8), 0);
    ticks(1); check("R11 no reload", int'(rst8), 1);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule